// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Reset Control

This block watches over software running on the chip. A free-running first divider stage produces a tick every 2^B clock cycles. A second stage counts those ticks up to a limit that a 3-bit rate field selects. Software proves it is alive by writing a two-byte service sequence before the limit is reached. If the sequence is missing or wrong, the block raises a reset request for a fixed number of cycles. A flag records whether the cause was the watchdog or the clock monitor.

A small control word carries the rate, a bit that forces a watchdog reset, a bit that enables clock-monitor resets, and a bit that blocks every reset source. An external "clock slow" input stands in for the analog clock detector. Write permission depends on a mode input. In normal mode the rate may be written once after power-on, and the three other bits cannot be written at all. In special mode every field may be written at any time.

Top module: `cop_watchdog`

## Requirements
- R1: After power-on reset, `rst_req` and `rst_cause_cm` are 0 and the control word is all zero, so no reset request is ever raised without further writes.
- R2: With rate code 000 the watchdog is off: no timeout occurs and service-port writes of any value have no effect.
- R3: Rate codes 1..7 select total divisors 2^(B+k), with k = 0, 2, 4, 6, 8, 9, 10 for codes 1..7 and B = `PRE_BITS`. After a restart of both stages, the request rises on the clock edge of the (2^k + 1)-th rollover of the 2^B first stage.
- R4: Writing 0x55 and then 0xAA to the service port restarts only the second stage. The first stage keeps its phase, so the timeout can run long by up to 2^B cycles.
- R5: While the watchdog is on, a service byte other than 0x55 or 0xAA, or 0xAA not preceded by 0x55, raises the reset request on the edge that captures it.
- R6: A reset event drives `rst_req` high for `PULSE_CYCLES` (default 16) consecutive cycles. `rst_cause_cm` is 0 for a watchdog cause and 1 for a clock-monitor cause.
- R7: In normal mode (`mode_special`=0) only the first control write after power-on changes the rate. Power-on reset re-arms that one write.
- R8: In normal mode, control writes leave the force-watchdog bit (4), the clock-monitor enable bit (3) and the disable bit (5) unchanged. In special mode all fields, including the rate in bits 2:0, are written on every write.
- R9: Force-watchdog bit 4 set with a nonzero rate raises a watchdog reset one cycle after the write. With rate 000 it has no effect.
- R10: Clock-monitor enable bit 3 set together with `clk_slow` high raises a clock-monitor reset with `rst_cause_cm`=1. With `clk_slow` low nothing happens.
- R11: While disable bit 5 is set, no new reset request is raised from any source, including force bits, timeouts and bad service bytes.
- R12: An accepted rate write restarts both divider stages.
- R13: When a watchdog event and a clock-monitor event occur together, the recorded cause is the watchdog (`rst_cause_cm`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency internal clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mode_special | input | 1 | 1 = special mode (free writes), 0 = normal mode |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: [2:0] rate, [3] clock-monitor enable, [4] force watchdog, [5] disable |
| svc_we | input | 1 | Service port write strobe |
| svc_wdata | input | 8 | Service byte |
| clk_slow | input | 1 | Clock detector output: 1 = clock slow or stopped |
| rst_req | output | 1 | Reset request pulse |
| rst_cause_cm | output | 1 | Cause of the latest reset event: 1 = clock monitor, 0 = watchdog |

## Verification
Every rate code is started from a fresh restart, and the cycle of the first request is compared with the rollover count expected for that code. This separates the irregular divisor steps from a uniform doubling. A service completed mid-phase checks that only the second stage restarts: a design that also cleared the first stage would time out five cycles later. Repeated rate writes in both modes separate write-once locking from restart-on-write. Force, clock-slow and disable combinations, each with and without its enabling condition, show which bits gate which source and which cause wins.

// File: rtl/cop_pkg.sv
package cop_pkg;
    localparam int RATE_W   = 3;
    localparam int CTL_W    = 6;
    localparam int SVC_W    = 8;
    localparam int SHIFT_W  = 4;
    localparam int OFF_MAX  = 10;

    localparam logic [SVC_W-1:0] SVC_ARM  = 8'h55;
    localparam logic [SVC_W-1:0] SVC_FIRE = 8'hAA;

    // packed order sets the bit positions of the control word
    typedef struct packed {
        logic              blk_all;
        logic              force_wd;
        logic              cm_en;
        logic [RATE_W-1:0] rate;
    } ctl_t;

    function automatic logic [SHIFT_W-1:0] rate_shift(input logic [RATE_W-1:0] r);
        case (r)
            3'd1:    rate_shift = 4'd0;
            3'd2:    rate_shift = 4'd2;
            3'd3:    rate_shift = 4'd4;
            3'd4:    rate_shift = 4'd6;
            3'd5:    rate_shift = 4'd8;
            3'd6:    rate_shift = 4'd9;
            3'd7:    rate_shift = 4'd10;
            default: rate_shift = 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/cop_ctrl.sv
module cop_ctrl
    import cop_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             mode_special,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl,
    output logic             rate_restart
);
    typedef struct packed {
        ctl_t ctl;
        logic locked;
    } st_t;

    st_t st_d, st_q;
    logic rate_ok;

    always_comb begin
        st_d         = st_q;
        rate_ok      = mode_special || !st_q.locked;
        rate_restart = we && rate_ok;
        if (we) begin
            if (mode_special) begin
                st_d.ctl = ctl_t'(wdata);
            end else begin
                if (rate_ok) st_d.ctl.rate = wdata[RATE_W-1:0];
                st_d.locked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;

    // R7: once locked, a normal-mode write leaves the rate alone
    a_r7_rate_once: assert property (@(posedge clk) disable iff (!por_n)
        (we && !mode_special && st_q.locked) |=> $stable(st_q.ctl.rate));

    // R8: normal-mode writes never touch the force and disable bits
    a_r8_force_locked: assert property (@(posedge clk) disable iff (!por_n)
        (we && !mode_special) |=> ($stable(st_q.ctl.force_wd) && $stable(st_q.ctl.cm_en)
                                   && $stable(st_q.ctl.blk_all)));
endmodule

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
    parameter int PRE_BITS = 13
) (
    input  logic clk,
    input  logic por_n,
    input  logic enable,
    input  logic clear,
    output logic tick
);
    typedef struct packed {
        logic [PRE_BITS-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear || !enable) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
        tick = enable && (st_q.cnt == '1);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: a clear leaves the first stage at zero on the next cycle
    a_r12_pre_clear: assert property (@(posedge clk) disable iff (!por_n)
        clear |=> (st_q.cnt == '0));
endmodule

// File: rtl/cop_timeout.sv
module cop_timeout
    import cop_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              tick,
    input  logic              restart,
    output logic              expire
);
    localparam int CNT_W = OFF_MAX + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] target;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        target = {{(CNT_W-1){1'b0}}, 1'b1} << rate_shift(rate);
        if (rate == '0 || restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == target) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the tick count never passes the limit of the selected rate
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt <= target);

    // R2: with the watchdog off the second stage stays idle
    a_r2_off_idle: assert property (@(posedge clk) disable iff (!por_n)
        (rate == '0) |=> (st_q.cnt == '0));
endmodule

// File: rtl/cop_service.sv
module cop_service
    import cop_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             enable,
    input  logic             we,
    input  logic [SVC_W-1:0] data,
    output logic             good,
    output logic             bad
);
    typedef struct packed {
        logic armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        good = 1'b0;
        bad  = 1'b0;
        if (!enable) begin
            st_d.armed = 1'b0;
        end else if (we) begin
            if (data == SVC_ARM) begin
                st_d.armed = 1'b1;
            end else if (data == SVC_FIRE && st_q.armed) begin
                good       = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                bad        = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a completed sequence always leaves the detector disarmed
    a_r4_disarm: assert property (@(posedge clk) disable iff (!por_n)
        good |=> !st_q.armed);
endmodule

// File: rtl/cop_reset_gen.sv
module cop_reset_gen #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic wd_evt,
    input  logic cm_evt,
    input  logic block,
    output logic req,
    output logic cause_cm
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          cause;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (!block && (wd_evt || cm_evt)) begin
            st_d.cnt   = PW'(PULSE_CYCLES);
            st_d.cause = !wd_evt;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req      = (st_q.cnt != '0);
    assign cause_cm = st_q.cause;

    // R11: with the block bit set, an idle output stays idle
    a_r11_block_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (block && !req) |=> !req);

    // R6: each pulse starts at full length
    a_r6_full_pulse: assert property (@(posedge clk) disable iff (!por_n)
        $rose(req) |-> (st_q.cnt == PW'(PULSE_CYCLES)));

    // R13: simultaneous sources record the watchdog
    a_r13_wd_first: assert property (@(posedge clk) disable iff (!por_n)
        (!req && !block && wd_evt && cm_evt) |=> !cause_cm);
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int PRE_BITS     = 13,
    parameter int PULSE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mode_special,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             svc_we,
    input  logic [SVC_W-1:0] svc_wdata,
    input  logic             clk_slow,
    output logic             rst_req,
    output logic             rst_cause_cm
);
    ctl_t ctl;
    logic rate_restart, wd_on, tick, expire, svc_good, svc_bad;
    logic wd_evt, cm_evt;

    cop_ctrl u_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .mode_special (mode_special),
        .we           (ctl_we),
        .wdata        (ctl_wdata),
        .ctl          (ctl),
        .rate_restart (rate_restart)
    );

    assign wd_on = (ctl.rate != '0);

    cop_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk    (clk),
        .por_n  (por_n),
        .enable (wd_on),
        .clear  (rate_restart),
        .tick   (tick)
    );

    cop_service u_svc (
        .clk    (clk),
        .por_n  (por_n),
        .enable (wd_on),
        .we     (svc_we),
        .data   (svc_wdata),
        .good   (svc_good),
        .bad    (svc_bad)
    );

    cop_timeout u_tmo (
        .clk     (clk),
        .por_n   (por_n),
        .rate    (ctl.rate),
        .tick    (tick),
        .restart (rate_restart || svc_good || svc_bad),
        .expire  (expire)
    );

    assign wd_evt = expire || svc_bad || (ctl.force_wd && wd_on);
    assign cm_evt = ctl.cm_en && clk_slow;

    cop_reset_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_rst (
        .clk      (clk),
        .por_n    (por_n),
        .wd_evt   (wd_evt),
        .cm_evt   (cm_evt),
        .block    (ctl.blk_all),
        .req      (rst_req),
        .cause_cm (rst_cause_cm)
    );

    // R5: a bad service byte raises the request on the next cycle
    a_r5_bad_service: assert property (@(posedge clk) disable iff (!por_n)
        (svc_bad && !ctl.blk_all && !rst_req) |=> rst_req);

    // R10: slow clock with monitoring enabled gives a clock-monitor cause
    a_r10_cm_cause: assert property (@(posedge clk) disable iff (!por_n)
        (cm_evt && !wd_evt && !ctl.blk_all && !rst_req) |=> (rst_req && rst_cause_cm));
endmodule

// File: tb/cop_watchdog_tb.sv
module cop_watchdog_tb;
    localparam int PB = 3;
    localparam logic [5:0] B_CM  = 6'h08;
    localparam logic [5:0] B_FWD = 6'h10;
    localparam logic [5:0] B_DIS = 6'h20;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mode_special = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       svc_we = 1'b0;
    logic [7:0] svc_wdata = '0;
    logic       clk_slow = 1'b0;
    logic       rst_req, rst_cause_cm;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cop_watchdog #(.PRE_BITS(PB), .PULSE_CYCLES(16)) u_dut (
        .clk(clk), .por_n(por_n), .mode_special(mode_special),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .svc_we(svc_we), .svc_wdata(svc_wdata),
        .clk_slow(clk_slow), .rst_req(rst_req), .rst_cause_cm(rst_cause_cm)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_por(input logic special);
        por_n = 1'b0; ctl_we = 1'b0; svc_we = 1'b0; clk_slow = 1'b0;
        mode_special = special;
        step(); step(); step();
        por_n = 1'b1;
        step();
    endtask

    task automatic write_ctl(input logic [5:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic svc_byte(input logic [7:0] b);
        svc_we = 1'b1; svc_wdata = b;
        step();
        svc_we = 1'b0;
    endtask

    task automatic wait_req(input int limit, output int at);
        at = -1;
        while (cyc < limit) begin
            step();
            if (rst_req) begin
                at = cyc;
                return;
            end
        end
    endtask

    function automatic int expect_at(input int code);
        int offs[8] = '{0, 0, 2, 4, 6, 8, 9, 10};
        return (1 << PB) * ((1 << offs[code]) + 1);
    endfunction

    task automatic t_reset();
        int at;
        do_por(1'b1);
        chk("R1", "rst_req after por", rst_req, 0);
        chk("R1", "cause after por", rst_cause_cm, 0);
        cyc = 0;
        wait_req(200, at);
        chk("R1", "no request with reset control word", at, -1);
    endtask

    task automatic t_rates();
        int at, w;
        for (int code = 1; code < 8; code++) begin
            do_por(1'b1);
            write_ctl(6'(code));
            cyc = 0;
            wait_req(expect_at(code) + 50, at);
            chk("R3", $sformatf("timeout cycle code %0d", code), at, expect_at(code));
            if (code == 1) begin
                chk("R6", "watchdog cause", rst_cause_cm, 0);
                w = 1;
                for (int i = 0; i < 40; i++) begin
                    step();
                    if (!rst_req) break;
                    w++;
                end
                chk("R6", "pulse width", w, 16);
            end
        end
    endtask

    task automatic t_service();
        int at;
        do_por(1'b1);
        write_ctl(6'd2);
        cyc = 0;
        while (cyc < 19) step();
        chk("R4", "no request before service", rst_req, 0);
        svc_byte(8'h55);
        svc_byte(8'hAA);
        wait_req(200, at);
        chk("R4", "timeout keeps first-stage phase", at, 56);
    endtask

    task automatic t_bad();
        do_por(1'b1);
        write_ctl(6'd2);
        svc_byte(8'hAA);
        chk("R5", "lone 0xAA resets", rst_req, 1);
        chk("R5", "bad byte cause", rst_cause_cm, 0);
        do_por(1'b1);
        write_ctl(6'd2);
        svc_byte(8'h55);
        chk("R5", "0x55 alone no reset", rst_req, 0);
        svc_byte(8'h33);
        chk("R5", "foreign byte resets", rst_req, 1);
    endtask

    task automatic t_off_ignore();
        int at;
        do_por(1'b1);
        svc_byte(8'h12);
        svc_byte(8'hAA);
        cyc = 0;
        wait_req(30, at);
        chk("R2", "service ignored while off", at, -1);
    endtask

    task automatic t_lock();
        int at;
        do_por(1'b0);
        write_ctl(6'd1);
        cyc = 0;
        step(); step();
        write_ctl(6'd7);
        wait_req(100, at);
        chk("R7", "second normal write ignored", at, 16);
        do_por(1'b0);
        write_ctl(6'd2);
        cyc = 0;
        wait_req(100, at);
        chk("R7", "por re-arms rate write", at, 40);
    endtask

    task automatic t_restart();
        int at;
        do_por(1'b1);
        write_ctl(6'd2);
        cyc = 0;
        while (cyc < 30) step();
        chk("R12", "no request before rewrite", rst_req, 0);
        write_ctl(6'd2);
        cyc = 0;
        wait_req(100, at);
        chk("R12", "rewrite restarts both stages", at, 40);
    endtask

    task automatic t_normal_force();
        int at;
        do_por(1'b0);
        clk_slow = 1'b1;
        write_ctl(B_CM | B_FWD);
        cyc = 0;
        wait_req(60, at);
        chk("R8", "normal mode force bits not written", at, -1);
        clk_slow = 1'b0;
    endtask

    task automatic t_cm();
        int at;
        do_por(1'b1);
        write_ctl(B_CM);
        cyc = 0;
        wait_req(30, at);
        chk("R10", "enabled monitor, clock fine", at, -1);
        clk_slow = 1'b1;
        step();
        chk("R10", "slow clock request", rst_req, 1);
        chk("R10", "clock monitor cause", rst_cause_cm, 1);
        clk_slow = 1'b0;
    endtask

    task automatic t_force_wd();
        int at;
        do_por(1'b1);
        write_ctl(B_FWD);
        cyc = 0;
        wait_req(30, at);
        chk("R9", "force with rate off", at, -1);
        write_ctl(B_FWD | 6'd3);
        cyc = 0;
        wait_req(5, at);
        chk("R9", "force with rate on", at, 1);
        chk("R9", "forced cause", rst_cause_cm, 0);
    endtask

    task automatic t_disable();
        int at;
        do_por(1'b1);
        clk_slow = 1'b1;
        write_ctl(B_DIS | B_CM | B_FWD | 6'd1);
        cyc = 0;
        wait_req(100, at);
        chk("R11", "all sources blocked", at, -1);
        svc_byte(8'h12);
        step();
        chk("R11", "bad byte blocked", rst_req, 0);
        clk_slow = 1'b0;
    endtask

    task automatic t_prio();
        do_por(1'b1);
        clk_slow = 1'b1;
        write_ctl(B_CM | B_FWD | 6'd3);
        step();
        chk("R13", "request on joint event", rst_req, 1);
        chk("R13", "watchdog cause wins", rst_cause_cm, 0);
        clk_slow = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rates();
        t_service();
        t_bad();
        t_off_ignore();
        t_lock();
        t_restart();
        t_normal_force();
        t_cm();
        t_force_wd();
        t_disable();
        t_prio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule